// File: doc/BRIEF.md
# Timer Count-Source Divider

This block produces the count-source strobes for a set of timer prescalers. All logic runs on one system clock. The main oscillator and the sub oscillator each arrive as a one-cycle enable strobe in that clock domain. A 2-bit speed-mode field picks which strobe drives a shared free-running binary divider.

Each prescaler has its own 4-bit source-select field. The field picks one of ten power-of-two divide taps, from 1/2 to 1/1024. One prescaler, chosen by a parameter, can also take the sub-clock strobe directly, with no division. Every output is a registered single-cycle tick that the prescaler uses as its count enable.

Top module: `tmr_src_divider`

## Requirements
- R1: When `speed_mode` is 2'b00, 2'b01 or 2'b11, the divider advances once per `main_stb` pulse, and `sub_stb` has no effect on the divided taps.
- R2: When `speed_mode` is 2'b10, the divider advances once per `sub_stb` pulse, and `main_stb` has no effect on the divided taps.
- R3: A select code k from 0 to 9 in a prescaler's 4-bit field gives a ratio of 1/2^(k+1). Starting from reset, that prescaler gets one tick for every 2^(k+1) divider advances, and the first tick comes after the 2^(k+1)-th advance.
- R4: A tick is high for exactly one clock cycle. It appears two rising edges after the edge that samples the source strobe completing the count.
- R5: Select code 10 on the raw-capable prescaler (index `RAW_IDX`, the last one by default) forwards every `sub_stb` pulse as a tick, whatever the speed mode. The latency is the same two edges as in R4.
- R6: Select code 10 on any other prescaler produces no ticks.
- R7: Select codes 11 to 15 produce no ticks on any prescaler.
- R8: While `rst` is high, every tick output is low. Reset also clears the divider count to zero.
- R9: All prescalers share one divider. Each follows only its own select field, so different ratios run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| main_stb | input | 1 | One-cycle strobe per main oscillator period |
| sub_stb | input | 1 | One-cycle strobe per sub oscillator period |
| speed_mode | input | 2 | CPU speed mode: 00 high, 01 middle, 10 low (sub clock), 11 reserved (behaves as 00) |
| src_sel | input | NUM_PRESC*4 | Per-prescaler select; prescaler p uses bits [4p+3:4p] |
| tick | output | NUM_PRESC | Registered one-cycle count enable per prescaler |

## Verification
The bound assertions check several rules on every cycle:
- the divider count holds whenever the strobe picked by the speed mode is absent;
- no tap ever stays high for two consecutive cycles;
- reserved select codes, and code 10 on a prescaler without the raw option, never produce a tick;
- every tick can be traced back to a source strobe two cycles earlier.

The assertions cannot show the exact ratio of each tap, that the first tick after reset falls on the right advance, or that the ignored strobe really leaves the tick count unchanged. Only the bench sweeps show these, by counting ticks over long strobe trains in every speed mode and comparing them with the arithmetic expectation.

// File: rtl/tmr_src_pkg.sv
package tmr_src_pkg;

  typedef enum logic [1:0] {
    SPD_HIGH = 2'b00,
    SPD_MID  = 2'b01,
    SPD_LOW  = 2'b10,
    SPD_RSV  = 2'b11
  } speed_mode_e;

  // Only the low-speed code routes the sub clock; the reserved code acts as high speed.
  function automatic logic uses_sub(input logic [1:0] mode);
    return mode == SPD_LOW;
  endfunction

  function automatic int sel_width(input int stages);
    return $clog2(stages + 2);
  endfunction

endpackage

// File: rtl/tmr_src_mode_mux.sv
module tmr_src_mode_mux
  import tmr_src_pkg::*;
(
  input  logic       main_stb,
  input  logic       sub_stb,
  input  logic [1:0] speed_mode,
  output logic       src_stb
);

  always_comb begin
    if (uses_sub(speed_mode)) src_stb = sub_stb;
    else                      src_stb = main_stb;
  end

endmodule

// File: rtl/tmr_src_ripple_div.sv
module tmr_src_ripple_div #(
  parameter int DIV_STAGES = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  src_stb,
  input  logic                  sub_stb,
  output logic [DIV_STAGES-1:0] cnt,
  output logic [DIV_STAGES-1:0] taps,
  output logic                  raw_sub
);

  logic [DIV_STAGES-1:0] cnt_q;
  logic [DIV_STAGES-1:0] tap_q;
  logic                  raw_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (src_stb) cnt_q <= cnt_q + 1'b1;
  end

  // Tap k fires when the low k+1 bits wrap on this advance.
  for (genvar k = 0; k < DIV_STAGES; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap_q[k] <= 1'b0;
      else     tap_q[k] <= src_stb & (&cnt_q[k:0]);
    end
  end

  // Raw sub strobe is delayed one stage to match the tap latency.
  always_ff @(posedge clk) begin
    if (rst) raw_q <= 1'b0;
    else     raw_q <= sub_stb;
  end

  assign cnt     = cnt_q;
  assign taps    = tap_q;
  assign raw_sub = raw_q;

endmodule

// File: rtl/tmr_src_tap_pick.sv
module tmr_src_tap_pick #(
  parameter int DIV_STAGES = 10,
  parameter bit HAS_RAW    = 1'b0,
  parameter int SEL_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIV_STAGES-1:0] taps,
  input  logic                  raw_sub,
  input  logic [SEL_W-1:0]      sel,
  output logic                  tick
);

  localparam logic [SEL_W-1:0] RAW_CODE = SEL_W'(DIV_STAGES);

  logic pick;
  logic tick_q;

  always_comb begin
    pick = 1'b0;
    for (int k = 0; k < DIV_STAGES; k++) begin
      if (sel == SEL_W'(k)) pick = taps[k];
    end
    if (HAS_RAW && (sel == RAW_CODE)) pick = raw_sub;
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= pick;
  end

  assign tick = tick_q;

endmodule

// File: rtl/tmr_src_divider.sv
module tmr_src_divider
  import tmr_src_pkg::*;
#(
  parameter  int NUM_PRESC  = 3,
  parameter  int DIV_STAGES = 10,
  parameter  int RAW_IDX    = NUM_PRESC - 1,
  localparam int SEL_W      = sel_width(DIV_STAGES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       main_stb,
  input  logic                       sub_stb,
  input  logic [1:0]                 speed_mode,
  input  logic [NUM_PRESC*SEL_W-1:0] src_sel,
  output logic [NUM_PRESC-1:0]       tick
);

  logic                  src_stb;
  logic [DIV_STAGES-1:0] div_cnt;
  logic [DIV_STAGES-1:0] tap_vec;
  logic                  raw_sub;

  tmr_src_mode_mux u_mux (
    .main_stb   (main_stb),
    .sub_stb    (sub_stb),
    .speed_mode (speed_mode),
    .src_stb    (src_stb)
  );

  tmr_src_ripple_div #(.DIV_STAGES(DIV_STAGES)) u_div (
    .clk     (clk),
    .rst     (rst),
    .src_stb (src_stb),
    .sub_stb (sub_stb),
    .cnt     (div_cnt),
    .taps    (tap_vec),
    .raw_sub (raw_sub)
  );

  for (genvar p = 0; p < NUM_PRESC; p++) begin : g_presc
    tmr_src_tap_pick #(
      .DIV_STAGES (DIV_STAGES),
      .HAS_RAW    (p == RAW_IDX),
      .SEL_W      (SEL_W)
    ) u_pick (
      .clk     (clk),
      .rst     (rst),
      .taps    (tap_vec),
      .raw_sub (raw_sub),
      .sel     (src_sel[p*SEL_W +: SEL_W]),
      .tick    (tick[p])
    );
  end

endmodule

// File: rtl/tmr_src_divider_chk.sv
module tmr_src_divider_chk #(
  parameter int NUM_PRESC  = 3,
  parameter int DIV_STAGES = 10,
  parameter int RAW_IDX    = 2,
  parameter int SEL_W      = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       main_stb,
  input logic                       sub_stb,
  input logic [1:0]                 speed_mode,
  input logic [NUM_PRESC*SEL_W-1:0] src_sel,
  input logic [NUM_PRESC-1:0]       tick,
  input logic [DIV_STAGES-1:0]      cnt,
  input logic [DIV_STAGES-1:0]      taps
);

  AST_MAIN_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (speed_mode != 2'b10 && !main_stb) |=> $stable(cnt)); // R1

  AST_SUB_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (speed_mode == 2'b10 && !sub_stb) |=> $stable(cnt)); // R2

  AST_TAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (taps & $past(taps)) == '0); // R4

  for (genvar p = 0; p < NUM_PRESC; p++) begin : g_chk
    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
      (src_sel[p*SEL_W +: SEL_W] > SEL_W'(DIV_STAGES)) |=> !tick[p]); // R7

    AST_TICK_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
      tick[p] |-> $past(main_stb || sub_stb, 2)); // R4

    if (p != RAW_IDX) begin : g_noraw
      AST_NO_RAW_PLAIN: assert property (@(posedge clk) disable iff (rst)
        (src_sel[p*SEL_W +: SEL_W] == SEL_W'(DIV_STAGES)) |=> !tick[p]); // R6
    end
  end

endmodule

bind tmr_src_divider tmr_src_divider_chk #(
  .NUM_PRESC  (NUM_PRESC),
  .DIV_STAGES (DIV_STAGES),
  .RAW_IDX    (RAW_IDX),
  .SEL_W      (SEL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .main_stb   (main_stb),
  .sub_stb    (sub_stb),
  .speed_mode (speed_mode),
  .src_sel    (src_sel),
  .tick       (tick),
  .cnt        (div_cnt),
  .taps       (tap_vec)
);

// File: tb/tb_tmr_src_divider.sv
module tb_tmr_src_divider;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          main_stb = 1'b0;
  logic          sub_stb = 1'b0;
  logic [1:0]    speed_mode = 2'b00;
  logic [NP*SW-1:0] src_sel = '0;
  logic [NP-1:0] tick;

  int n_checks = 0;
  int n_fail = 0;
  int seen [NP];
  bit done = 1'b0;

  tmr_src_divider dut (
    .clk(clk), .rst(rst), .main_stb(main_stb), .sub_stb(sub_stb),
    .speed_mode(speed_mode), .src_sel(src_sel), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) if (!rst && tick[p]) seen[p]++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; main_stb = 1'b0; sub_stb = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < NP; p++) seen[p] = 0;
  endtask

  // Expected ticks for prescaler p from arithmetic on strobe counts.
  function automatic int expect_ticks(input int p, input int sel, input int mode,
                                      input int m, input int s);
    int src;
    src = (mode == 2) ? s : m;
    if (sel < 10) return src / (1 << (sel + 1));
    if (sel == 10 && p == NP - 1) return s;
    return 0;
  endfunction

  task automatic run(input int mode, input int s0, input int s1, input int s2,
                     input int ncyc);
    int m, s;
    int sels [NP];
    sels[0] = s0; sels[1] = s1; sels[2] = s2;
    speed_mode = 2'(mode);
    src_sel = {4'(s2), 4'(s1), 4'(s0)};
    do_reset();
    m = 0; s = 0;
    for (int i = 0; i < ncyc; i++) begin
      main_stb = (i % 2 == 0);
      sub_stb  = (i % 3 == 0);
      if (main_stb) m++;
      if (sub_stb) s++;
      @(negedge clk);
    end
    main_stb = 1'b0; sub_stb = 1'b0;
    repeat (4) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      string tag;
      if (sels[p] > 10) tag = "R7 reserved";
      else if (sels[p] == 10) tag = (p == NP - 1) ? "R5 raw sub" : "R6 raw on plain";
      else tag = (mode == 2) ? "R2/R3/R9 sub ratio" : "R1/R3/R9 main ratio";
      check(tag, seen[p], expect_ticks(p, sels[p], mode, m, s));
    end
  endtask

  initial begin
    // R8: outputs low during reset even with strobes present
    speed_mode = 2'b00; src_sel = '0;
    main_stb = 1'b1; sub_stb = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 reset outputs", int'(tick), 0);

    // R4: exact latency and width on the 1/2 tap
    do_reset();
    main_stb = 1'b1; @(negedge clk);
    @(negedge clk);
    main_stb = 1'b0;
    check("R4 no tick yet", int'(tick[0]), 0);
    @(negedge clk);
    check("R4 tick two edges later", int'(tick[0]), 1);
    @(negedge clk);
    check("R4 single cycle", int'(tick[0]), 0);

    // R5: raw sub latency on the raw-capable prescaler
    src_sel = {4'd10, 4'd0, 4'd0};
    do_reset();
    sub_stb = 1'b1; @(negedge clk);
    sub_stb = 1'b0;
    check("R5 raw not yet", int'(tick[2]), 0);
    @(negedge clk);
    check("R5 raw tick", int'(tick[2]), 1);

    // Directed: top tap, raw on plain, raw on capable
    run(0, 9, 10, 10, 4200);
    run(2, 9, 10, 10, 6200);
    run(3, 12, 15, 11, 600);

    // Near-exhaustive sweep of select codes across all speed modes
    for (int md = 0; md < 4; md++) begin
      for (int r = 0; r < 6; r++) begin
        run(md, (r*3 + md) % 16, (r*3 + 6 + md) % 16, (r*3 + 12 + md) % 16, 4200);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule